// File: doc/BRIEF.md
# Cascadable Column Driver Data Loader

This block is the digital front end of one column driver in a chain of drivers along the edge of a flat panel. A pixel bus carries three 6-bit gray codes per shift clock. A write pointer walks across the driver's column groups, one group of three columns per clock, and stores each bus word in a data register. A rising edge on the strobe copies the whole data register into an output latch in one step. That latch holds the codes that the later conversion stage uses. The strobe also parks the pointer, so the next line starts from a clean state.

A scan begins when a start pulse arrives on one of the two start pins. When the last group of this driver has been written, a one-cycle start pulse leaves on the opposite pin and starts the next driver in the chain. The direction input selects which pin is the input and which is the output, and it also sets which end of the column row is filled first. A count-select input can switch to a reduced column count, in which a fixed band of groups in the middle of the row is skipped. An invert input complements the pixel codes as they are stored.

Top module: `colDriverLoader`

## Requirements
- R1: While the active-low reset is asserted and directly after it, every latched column code is zero and both start output pins are low.
- R2: After reset, start pulses cause no writes and no cascade pulse until the first strobe rising edge has been seen.
- R3: Bus bits [5:0], [11:6] and [17:12] are stored in the lowest, middle and highest column of the addressed group. Within a group, column c uses `colCodes` bits [(3*g+c)*6 +: 6], and bit 0 of each code is its LSB.
- R4: When `dirRight` is 1, `startRIn` is the start input and the left pin is the output (`startLOe`=1, `startROe`=0). The clock that samples the start pulse writes group 0, and each following clock writes the next higher group.
- R5: When `dirRight` is 0, the pin roles are swapped (`startROe`=1, `startLOe`=0). The clock that samples the start pulse writes the highest group, and the fill runs toward group 0.
- R6: On the output start pin, the cascade pulse is high for exactly one cycle. It is driven from the rising clock edge that writes the last group, which is clock NUM_GROUPS when the sampling clock counts as clock 1.
- R7: When `fullCount` is 0, groups SKIP_FIRST through SKIP_FIRST+SKIP_COUNT-1 are never written and keep their previous values, and the cascade pulse comes on clock NUM_GROUPS-SKIP_COUNT.
- R8: When `invertData` is 1, every stored code is the bitwise complement of the bus code. When it is 0, the code is stored unchanged.
- R9: The output latch loads the full data register on the clock edge at which `strobe` is first sampled high. It changes at no other time, including while `strobe` stays high.
- R10: A strobe rising edge ends any scan in progress. Later clocks without a new start pulse write nothing, and no cascade pulse follows.
- R11: Clocks that arrive while no scan is in progress leave the data register unchanged.
- R12: A start pulse that arrives during a scan restarts the scan at its first group on that same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock |
| rstN | input | 1 | Asynchronous active-low reset |
| dirRight | input | 1 | 1: fill from group 0 upward; 0: fill from the top group downward |
| fullCount | input | 1 | 1: all groups used; 0: middle band skipped |
| invertData | input | 1 | Complement codes on load |
| strobe | input | 1 | Latch strobe, acts on its rising edge |
| pixBus | input | DOTS*PIX_W | Three packed pixel codes |
| startRIn | input | 1 | Right start pin, input side |
| startROut | output | 1 | Right start pin, output side |
| startROe | output | 1 | Right start pin output enable |
| startLIn | input | 1 | Left start pin, input side |
| startLOut | output | 1 | Left start pin, output side |
| startLOe | output | 1 | Left start pin output enable |
| colCodes | output | NUM_GROUPS*DOTS*PIX_W | Latched codes of every column |

## Verification
The bench builds the loader with 10 groups and a skipped band of 2 groups that starts at group 3. This places the band off centre, so the two fill directions skip different step numbers, and a mapping that assumes a symmetric band would fail. With the small group count, every scan reaches its cascade pulse within a few cycles. This allows full and reduced scans in both directions, with and without inversion, as well as restarts, early strobes and idle clocking, each compared on every cycle against the reference model.

// File: rtl/colDrvPkg.sv
package colDrvPkg;
  localparam int IDX_W = 16;

  typedef struct packed {
    logic             wrEn;
    logic [IDX_W-1:0] wrGroup;
    logic             latchEn;
  } drvCtl_t;
endpackage

// File: rtl/colDrvCtrl.sv
module colDrvCtrl
  import colDrvPkg::*;
#(
  parameter int NUM_GROUPS = 134,
  parameter int SKIP_FIRST = 64,
  parameter int SKIP_COUNT = 6
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    dirRight,
  input  logic    fullCount,
  input  logic    strobe,
  input  logic    startRIn,
  input  logic    startLIn,
  output drvCtl_t ctl,
  output logic    cascade
);
  localparam int UPPER = NUM_GROUPS - SKIP_FIRST - SKIP_COUNT;
  localparam logic [IDX_W-1:0] LAST_FULL = IDX_W'(NUM_GROUPS - 1);
  localparam logic [IDX_W-1:0] LAST_RED  = IDX_W'(NUM_GROUPS - SKIP_COUNT - 1);

  logic             primed, strobePrev, active;
  logic [IDX_W-1:0] step, curStep, lastStep;
  logic             startIn, strobeRise, doWrite;
  int               physIdx;

  always_comb begin
    strobeRise = strobe & ~strobePrev;
    startIn    = dirRight ? startRIn : startLIn;
    lastStep   = fullCount ? LAST_FULL : LAST_RED;
    curStep    = startIn ? '0 : step;
    doWrite    = primed & ~strobeRise & (startIn | active);
  end

  // step number -> physical group, skipping the middle band in reduced mode
  always_comb begin
    if (dirRight) begin
      if (!fullCount && int'(curStep) >= SKIP_FIRST) physIdx = int'(curStep) + SKIP_COUNT;
      else                                           physIdx = int'(curStep);
    end else begin
      if (!fullCount && int'(curStep) >= UPPER) physIdx = NUM_GROUPS - 1 - SKIP_COUNT - int'(curStep);
      else                                      physIdx = NUM_GROUPS - 1 - int'(curStep);
    end
  end

  always_comb begin
    ctl.wrEn    = doWrite;
    ctl.wrGroup = IDX_W'(physIdx);
    ctl.latchEn = strobeRise;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      primed     <= 1'b0;
      strobePrev <= 1'b0;
      active     <= 1'b0;
      step       <= '0;
      cascade    <= 1'b0;
    end else begin
      strobePrev <= strobe;
      if (strobeRise) begin
        primed  <= 1'b1;
        active  <= 1'b0;
        step    <= '0;
        cascade <= 1'b0;
      end else if (doWrite) begin
        cascade <= (curStep == lastStep);
        active  <= (curStep != lastStep);
        step    <= curStep + 1'b1;
      end else begin
        cascade <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/colDrvData.sv
module colDrvData
  import colDrvPkg::*;
#(
  parameter int NUM_GROUPS = 134,
  parameter int PIX_W      = 6,
  parameter int DOTS       = 3
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  drvCtl_t                     ctl,
  input  logic                        invertData,
  input  logic [DOTS*PIX_W-1:0]       pixBus,
  output logic [NUM_GROUPS*DOTS*PIX_W-1:0] latchOut
);
  localparam int GRP_W = DOTS * PIX_W;

  logic [GRP_W-1:0] loadWord;
  assign loadWord = invertData ? ~pixBus : pixBus;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : gGroup
    logic [GRP_W-1:0] dataReg;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                        dataReg <= '0;
      else if (ctl.wrEn && ctl.wrGroup == IDX_W'(g))    dataReg <= loadWord;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            latchOut[g*GRP_W +: GRP_W] <= '0;
      else if (ctl.latchEn) latchOut[g*GRP_W +: GRP_W] <= dataReg;
    end
  end
endmodule

// File: rtl/colDriverLoader.sv
module colDriverLoader
  import colDrvPkg::*;
#(
  parameter int NUM_GROUPS = 134,
  parameter int SKIP_FIRST = 64,
  parameter int SKIP_COUNT = 6,
  parameter int PIX_W      = 6,
  parameter int DOTS       = 3
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             dirRight,
  input  logic                             fullCount,
  input  logic                             invertData,
  input  logic                             strobe,
  input  logic [DOTS*PIX_W-1:0]            pixBus,
  input  logic                             startRIn,
  output logic                             startROut,
  output logic                             startROe,
  input  logic                             startLIn,
  output logic                             startLOut,
  output logic                             startLOe,
  output logic [NUM_GROUPS*DOTS*PIX_W-1:0] colCodes
);
  drvCtl_t ctl;
  logic    cascade;

  colDrvCtrl #(.NUM_GROUPS(NUM_GROUPS), .SKIP_FIRST(SKIP_FIRST), .SKIP_COUNT(SKIP_COUNT)) uCtrl (
    .clk(clk), .rstN(rstN), .dirRight(dirRight), .fullCount(fullCount), .strobe(strobe),
    .startRIn(startRIn), .startLIn(startLIn), .ctl(ctl), .cascade(cascade)
  );

  colDrvData #(.NUM_GROUPS(NUM_GROUPS), .PIX_W(PIX_W), .DOTS(DOTS)) uData (
    .clk(clk), .rstN(rstN), .ctl(ctl), .invertData(invertData), .pixBus(pixBus), .latchOut(colCodes)
  );

  assign startLOe  = dirRight;
  assign startROe  = ~dirRight;
  assign startLOut = dirRight & cascade;
  assign startROut = ~dirRight & cascade;
endmodule

// File: rtl/colDrvChecker.sv
module colDrvChecker
  import colDrvPkg::*;
#(
  parameter int NUM_GROUPS = 134,
  parameter int SKIP_FIRST = 64,
  parameter int SKIP_COUNT = 6,
  parameter int CODES_W    = 2412
) (
  input logic               clk,
  input logic               rstN,
  input logic               strobe,
  input logic               fullCount,
  input logic               startROut,
  input logic               startLOut,
  input logic [CODES_W-1:0] colCodes,
  input drvCtl_t            ctl
);
  // R6
  cascade_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    (startLOut || startROut) |=> !(startLOut || startROut));

  // R9
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe |=> $stable(colCodes));

  // R10
  strobe_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobe) |=> !(startLOut || startROut));

  // R7
  skip_band_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.wrEn && !fullCount) |->
      (int'(ctl.wrGroup) < SKIP_FIRST || int'(ctl.wrGroup) >= SKIP_FIRST + SKIP_COUNT));

  // R3
  group_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.wrEn |-> int'(ctl.wrGroup) < NUM_GROUPS);
endmodule

bind colDriverLoader colDrvChecker #(
  .NUM_GROUPS(NUM_GROUPS), .SKIP_FIRST(SKIP_FIRST), .SKIP_COUNT(SKIP_COUNT),
  .CODES_W(NUM_GROUPS*DOTS*PIX_W)
) uChk (
  .clk(clk), .rstN(rstN), .strobe(strobe), .fullCount(fullCount),
  .startROut(startROut), .startLOut(startLOut), .colCodes(colCodes), .ctl(ctl)
);

// File: tb/tb_colDriverLoader.sv
module tb_colDriverLoader;
  localparam int NG = 10, SF = 3, SC = 2, PW = 6, DT = 3;
  localparam int GW = DT * PW;
  localparam int VW = NG * GW;

  logic clk = 0, rstN = 0;
  logic dirRight = 1, fullCount = 1, invertData = 0, strobe = 0;
  logic [GW-1:0] pixBus = '0;
  logic startRIn = 0, startLIn = 0;
  logic startROut, startROe, startLOut, startLOe;
  logic [VW-1:0] colCodes;

  colDriverLoader #(.NUM_GROUPS(NG), .SKIP_FIRST(SF), .SKIP_COUNT(SC), .PIX_W(PW), .DOTS(DT)) dut (
    .clk(clk), .rstN(rstN), .dirRight(dirRight), .fullCount(fullCount), .invertData(invertData),
    .strobe(strobe), .pixBus(pixBus), .startRIn(startRIn), .startROut(startROut), .startROe(startROe),
    .startLIn(startLIn), .startLOut(startLOut), .startLOe(startLOe), .colCodes(colCodes)
  );

  always #4 clk = ~clk;

  int total = 0, bad = 0;
  string curReq = "R1";
  bit finished = 0;

  // behavioural reference model
  logic [GW-1:0] mData[NG];
  logic [GW-1:0] mLatch[NG];
  bit mPrimed, mActive, mCasc, mStbPrev;
  int mStep;
  int order[$];

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int g = 0; g < NG; g++) begin mData[g] = '0; mLatch[g] = '0; end
      mPrimed = 0; mActive = 0; mCasc = 0; mStbPrev = 0; mStep = 0;
    end else begin
      bit rise, sIn;
      int k;
      rise = strobe && !mStbPrev;
      mStbPrev = strobe;
      order.delete();
      for (int g = 0; g < NG; g++) if (fullCount || g < SF || g >= SF + SC) order.push_back(g);
      if (!dirRight) order.reverse();
      sIn = dirRight ? startRIn : startLIn;
      if (rise) begin
        for (int g = 0; g < NG; g++) mLatch[g] = mData[g];
        mActive = 0; mStep = 0; mCasc = 0; mPrimed = 1;
      end else if (mPrimed && (sIn || mActive)) begin
        k = sIn ? 0 : mStep;
        mData[order[k]] = invertData ? ~pixBus : pixBus;
        mCasc = (k == order.size() - 1);
        mActive = !mCasc;
        mStep = k + 1;
      end else begin
        mCasc = 0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // per-cycle comparison, between edges after inputs have settled
  always @(negedge clk) begin
    #2;
    if (rstN && !finished) begin
      logic [VW-1:0] expV;
      for (int g = 0; g < NG; g++) expV[g*GW +: GW] = mLatch[g];
      chk(colCodes === expV, curReq, colCodes, expV);
      chk(startLOut === (dirRight & mCasc), curReq, VW'(startLOut), VW'(dirRight & mCasc));
      chk(startROut === (!dirRight & mCasc), curReq, VW'(startROut), VW'(!dirRight & mCasc));
      chk({startLOe, startROe} === {dirRight, !dirRight}, curReq,
          VW'({startLOe, startROe}), VW'({dirRight, !dirRight}));
    end
  end

  function automatic logic [GW-1:0] pat(input int seed, input int c);
    return GW'(seed * 40503 + c * 977 + 5);
  endfunction

  // start a scan and report the clock number at which the cascade pulse appears
  task automatic scan(input bit dir, input bit full, input bit inv, input int seed,
                      input int nCyc, output int seen);
    seen = -1;
    @(negedge clk);
    dirRight = dir; fullCount = full; invertData = inv;
    startRIn = dir; startLIn = !dir; pixBus = pat(seed, 0);
    for (int c = 1; c <= nCyc; c++) begin
      @(negedge clk);
      startRIn = 0; startLIn = 0; pixBus = pat(seed, c);
      #3;
      if ((dir ? startLOut : startROut) && seen < 0) seen = c;
    end
  endtask

  task automatic pulseStrobe(input int hold);
    @(negedge clk); strobe = 1;
    for (int i = 0; i < hold; i++) @(negedge clk);
    strobe = 0;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 100000);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seen;
    // R1 reset state
    repeat (2) @(negedge clk);
    #2;
    chk(colCodes === '0, "R1", colCodes, '0);
    chk({startLOut, startROut} === 2'b00, "R1", VW'({startLOut, startROut}), '0);
    rstN = 1;
    @(negedge clk);

    // R2 start ignored before the first strobe
    curReq = "R2";
    scan(1, 1, 0, 1, NG + 2, seen);
    chk(seen == -1, "R2", VW'(seen), VW'(-1));
    pulseStrobe(1);
    chk(colCodes === '0, "R2", colCodes, '0);

    // R4 / R3 / R6 right fill, full count
    curReq = "R4";
    scan(1, 1, 0, 2, NG + 2, seen);
    chk(seen == NG, "R6", VW'(seen), VW'(NG));
    curReq = "R3";
    pulseStrobe(1);
    chk(colCodes[PW-1:0] === pat(2, 0)[PW-1:0], "R3", VW'(colCodes[PW-1:0]), VW'(pat(2, 0)[PW-1:0]));

    // R5 left fill, full count
    curReq = "R5";
    scan(0, 1, 0, 3, NG + 2, seen);
    chk(seen == NG, "R5", VW'(seen), VW'(NG));
    pulseStrobe(1);
    chk(colCodes[VW-1 -: GW] === pat(3, 0), "R5", VW'(colCodes[VW-1 -: GW]), VW'(pat(3, 0)));

    // R7 reduced count, both directions
    curReq = "R7";
    scan(1, 0, 0, 4, NG + 2, seen);
    chk(seen == NG - SC, "R7", VW'(seen), VW'(NG - SC));
    pulseStrobe(1);
    scan(0, 0, 0, 5, NG + 2, seen);
    chk(seen == NG - SC, "R7", VW'(seen), VW'(NG - SC));
    pulseStrobe(1);
    chk(colCodes[SF*GW +: GW] === pat(3, NG - 1 - SF), "R7",
        VW'(colCodes[SF*GW +: GW]), VW'(pat(3, NG - 1 - SF)));

    // R8 inversion
    curReq = "R8";
    scan(1, 1, 1, 6, NG + 1, seen);
    pulseStrobe(1);
    chk(colCodes[GW-1:0] === ~pat(6, 0), "R8", VW'(colCodes[GW-1:0]), VW'(~pat(6, 0)));
    invertData = 0;

    // R9 strobe held high, data changing, latch must only load once
    curReq = "R9";
    scan(0, 1, 0, 7, 3, seen);
    pulseStrobe(5);

    // R10 strobe mid-scan ends it
    curReq = "R10";
    scan(1, 1, 0, 8, 3, seen);
    pulseStrobe(1);
    for (int c = 0; c < NG + 2; c++) begin
      @(negedge clk); pixBus = pat(9, c);
      #3;
      if (startLOut) seen = 99;
    end
    chk(seen != 99, "R10", VW'(seen), VW'(-1));
    pulseStrobe(1);

    // R11 idle clocks write nothing
    curReq = "R11";
    for (int c = 0; c < 6; c++) begin @(negedge clk); pixBus = pat(10, c); end
    pulseStrobe(1);

    // R12 restart mid-scan
    curReq = "R12";
    scan(1, 1, 0, 11, 3, seen);
    scan(1, 1, 0, 12, NG + 2, seen);
    chk(seen == NG, "R12", VW'(seen), VW'(NG));
    pulseStrobe(1);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule